// File: doc/BRIEF.md
# Bytecode Module Header and Section Walker

This block sits in front of the per-section handlers of a bytecode accelerator. It takes a compiled module one byte at a time over a valid/ready stream that an instruction-memory fetcher feeds. It keeps a program counter of the bytes it has accepted. It first checks an eight-byte header, then walks the sections one by one. For each section it takes an id byte and a byte length in LEB128 form, and then counts the payload bytes down to zero. While a section is open, a section-kind output tells downstream handlers which section owns the bytes now flowing. The block does not look inside the section payloads.

A one-hot memory records the standard sections that have finished. A section id that is not above every recorded id is rejected, so any section may be left out but none may be repeated or reordered. Custom sections (id 0) are exempt from this rule. A bad header, a bad id, an over-long length field, or a module total length that ends in the middle of an element stops the walker for good. It then holds `in_ready` low until reset. When the accepted byte count reaches `total_len` exactly at a section boundary, a module-complete strobe fires. The walker then rearms for the next module.

Back-pressure: a byte is taken only on a cycle with `in_valid` and `in_ready` both high. `in_ready` is high in every state except the halted one. The source may insert idle cycles at any point without changing the result.

Top module: `bytecode_section_walker`

## Requirements
- R1: The first eight accepted bytes must be 0x00, 0x61, 0x73, 0x6D, 0x01, 0x00, 0x00, 0x00 in that order. After the eighth byte matches, `hdr_ok_o` is high until the module completes.
- R2: If a header byte does not match, `err_o` rises the cycle after that byte. From then on `in_ready` is low, `pc_o` is frozen and no strobes fire, until reset.
- R3: After the header, each section is an id byte, then a length in LEB128 form (seven value bits per byte, least significant group first, bit 7 set when another byte follows), then that many payload bytes. `sec_done_o` pulses for one cycle, the cycle after the last payload byte is accepted. During the pulse, `sec_id_o` and `sec_len_o` show the section.
- R4: A section whose length decodes to zero completes right after its last length byte is accepted. This includes a non-minimal encoding such as 0x80 0x00.
- R5: `sec_kind_o` equals the low four bits of the section id from the cycle after the id byte is accepted until the last byte of that section is accepted. At all other times it is 4'hF, including during the `sec_done_o` pulse.
- R6: Ids 1 to 12 must appear in strictly rising order. An id equal to or below one already completed in the same module is an error. Ids that are left out are allowed.
- R7: Id 0 may appear any number of times, anywhere after the header.
- R8: An id above 12 is an error.
- R9: A length field whose fifth byte still has bit 7 set is an error.
- R10: When the accepted byte count reaches `total_len` on the last byte of the header or of a section, `mod_done_o` pulses and `pc_o` returns to 0. At the same time `hdr_ok_o` clears and the order memory is emptied, so the next module may use the same ids again without a reset.
- R11: If the accepted byte count reaches `total_len` anywhere else (inside the header, the id, the length or the payload), that is an error.
- R12: After reset, `in_ready` is high, `err_o` and `hdr_ok_o` are low, `pc_o` is 0 and `sec_kind_o` is 4'hF. `pc_o` counts accepted bytes only, and idle cycles in the stream change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Walker can take a byte (low only when halted) |
| in_data | input | 8 | Stream byte |
| total_len | input | PC_W | Module size in bytes |
| pc_o | output | PC_W | Bytes accepted so far in this module |
| hdr_ok_o | output | 1 | Header has been checked and matched |
| err_o | output | 1 | Walker halted on a format error |
| sec_kind_o | output | 4 | Id of the open section, 4'hF when none is open |
| sec_id_o | output | 8 | Id of the last section taken |
| sec_len_o | output | LEN_W | Decoded length of the last section |
| sec_done_o | output | 1 | One-cycle strobe: a section finished |
| mod_done_o | output | 1 | One-cycle strobe: the module finished |

## Verification
The hardest state to reach is a second module that reuses ids after the order memory has been emptied with no reset between the modules. To get there, the stimulus runs a full module with sections 1, 0, 3 and 10. It then sends a second module with gaps in the stream, starting again at section 1 and ending on section 2. A truncation case sets `total_len` short of the real stream, so the limit falls inside a payload. Another case puts a fifth length byte with its continuation bit set. A scoreboard holds the expected order of section, module and error events and checks each strobe against it as it appears.

// File: rtl/bcw_pkg.sv
`timescale 1ns/1ps
package bcw_pkg;
  localparam int SEC_IDS = 13;
  localparam logic [3:0] KIND_IDLE = 4'hF;
  typedef enum logic [2:0] {WK_HDR, WK_ID, WK_SIZE, WK_CONT, WK_HALT} walk_st_e;
endpackage

// File: rtl/bcw_hdr_match.sv
`timescale 1ns/1ps
module bcw_hdr_match (
  input  logic [2:0] idx_i,
  input  logic [7:0] byte_i,
  output logic       match_o
);
  logic [7:0] want;
  always_comb begin
    unique case (idx_i)
      3'd0: want = 8'h00;
      3'd1: want = 8'h61;
      3'd2: want = 8'h73;
      3'd3: want = 8'h6D;
      3'd4: want = 8'h01;
      default: want = 8'h00;
    endcase
    match_o = (byte_i == want);
  end
endmodule

// File: rtl/bcw_leb_len.sv
`timescale 1ns/1ps
module bcw_leb_len #(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             take_i,
  input  logic [7:0]       byte_i,
  output logic [LEN_W-1:0] value_o,
  output logic             last_o,
  output logic             ovf_o
);
  localparam int MAX_B = (LEN_W + 6) / 7;
  localparam int NB_W  = $clog2(MAX_B + 1);

  logic [LEN_W-1:0] acc_q;
  logic [NB_W-1:0]  nb_q;

  always_comb begin
    value_o = acc_q | (LEN_W'(byte_i[6:0]) << (7 * nb_q));
    last_o  = !byte_i[7];
    ovf_o   = byte_i[7] && (nb_q == NB_W'(MAX_B - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      acc_q <= '0;
      nb_q  <= '0;
    end else if (take_i) begin
      acc_q <= value_o;
      if (nb_q != NB_W'(MAX_B - 1)) nb_q <= nb_q + 1'b1;
    end
  end

  AST_LEB_NB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    nb_q <= NB_W'(MAX_B - 1)); // R9
endmodule

// File: rtl/bcw_order_guard.sv
`timescale 1ns/1ps
module bcw_order_guard #(
  parameter int NUM_IDS = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       mark_i,
  input  logic [7:0] mark_id_i,
  input  logic [7:0] cand_id_i,
  output logic       bad_o
);
  logic [NUM_IDS-1:0] done_q;
  logic               mark_hit;

  always_comb begin
    bad_o    = (cand_id_i >= 8'(NUM_IDS));
    mark_hit = 1'b0;
    for (int i = 1; i < NUM_IDS; i++) begin
      if (done_q[i] && cand_id_i != 8'd0 && cand_id_i <= 8'(i)) bad_o = 1'b1;
      if (mark_id_i == 8'(i)) mark_hit = done_q[i];
    end
  end

  assign done_q[0] = 1'b0;
  for (genvar g = 1; g < NUM_IDS; g++) begin : g_done
    always_ff @(posedge clk) begin
      if (!rst_n || clr_i)                    done_q[g] <= 1'b0;
      else if (mark_i && mark_id_i == 8'(g))  done_q[g] <= 1'b1;
    end
  end

  AST_NO_REMARK: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_i && mark_id_i != 8'd0) |-> !mark_hit); // R6
endmodule

// File: rtl/bytecode_section_walker.sv
`timescale 1ns/1ps
module bytecode_section_walker
  import bcw_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic [PC_W-1:0]  total_len,
  output logic [PC_W-1:0]  pc_o,
  output logic             hdr_ok_o,
  output logic             err_o,
  output logic [3:0]       sec_kind_o,
  output logic [7:0]       sec_id_o,
  output logic [LEN_W-1:0] sec_len_o,
  output logic             sec_done_o,
  output logic             mod_done_o
);
  walk_st_e         st_q, st_d;
  logic [PC_W-1:0]  pc_q, pc_d, pc_next;
  logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_d;
  logic [7:0]       id_q, id_d;
  logic [3:0]       kind_q, kind_d;
  logic             hdr_q, hdr_d, sdone_q, sdone_d, mdone_q, mdone_d;
  logic             fire, fail, edge_ok, mark, leb_clr, leb_take, guard_clr;
  logic             hdr_hit, guard_bad, leb_last, leb_ovf;
  logic [LEN_W-1:0] leb_val;

  assign in_ready = (st_q != WK_HALT);
  assign fire     = in_valid && in_ready;
  assign pc_next  = pc_q + 1'b1;

  bcw_hdr_match u_hdr (.idx_i(pc_q[2:0]), .byte_i(in_data), .match_o(hdr_hit));

  bcw_leb_len #(.LEN_W(LEN_W)) u_leb (
    .clk(clk), .rst_n(rst_n), .clr_i(leb_clr), .take_i(leb_take),
    .byte_i(in_data), .value_o(leb_val), .last_o(leb_last), .ovf_o(leb_ovf));

  bcw_order_guard #(.NUM_IDS(SEC_IDS)) u_guard (
    .clk(clk), .rst_n(rst_n), .clr_i(guard_clr), .mark_i(mark),
    .mark_id_i(id_q), .cand_id_i(in_data), .bad_o(guard_bad));

  always_comb begin
    st_d = st_q; pc_d = pc_q; cnt_d = cnt_q; id_d = id_q; len_d = len_q;
    kind_d = kind_q; hdr_d = hdr_q;
    sdone_d = 1'b0; mdone_d = 1'b0; fail = 1'b0; edge_ok = 1'b0; mark = 1'b0;
    leb_clr = 1'b0; leb_take = 1'b0; guard_clr = 1'b0;
    if (fire) begin
      unique case (st_q)
        WK_HDR: begin
          if (!hdr_hit) fail = 1'b1;
          else if (pc_q[2:0] == 3'd7) begin
            edge_ok = 1'b1; hdr_d = 1'b1; st_d = WK_ID;
          end
        end
        WK_ID: begin
          if (guard_bad) fail = 1'b1;
          else begin
            id_d = in_data; kind_d = in_data[3:0]; leb_clr = 1'b1; st_d = WK_SIZE;
          end
        end
        WK_SIZE: begin
          leb_take = 1'b1;
          if (leb_ovf) fail = 1'b1;
          else if (leb_last) begin
            len_d = leb_val;
            if (leb_val == '0) begin
              edge_ok = 1'b1; sdone_d = 1'b1; mark = 1'b1; kind_d = KIND_IDLE; st_d = WK_ID;
            end else begin
              cnt_d = leb_val; st_d = WK_CONT;
            end
          end
        end
        WK_CONT: begin
          if (cnt_q == LEN_W'(1)) begin
            edge_ok = 1'b1; sdone_d = 1'b1; mark = 1'b1; kind_d = KIND_IDLE; st_d = WK_ID;
          end
          cnt_d = cnt_q - 1'b1;
        end
        default: ;
      endcase
      if (!fail) begin
        pc_d = pc_next;
        if (pc_next == total_len) begin
          if (edge_ok) begin
            mdone_d = 1'b1; pc_d = '0; st_d = WK_HDR; hdr_d = 1'b0;
            guard_clr = 1'b1; kind_d = KIND_IDLE;
          end else fail = 1'b1;
        end
      end
      if (fail) begin
        st_d = WK_HALT; pc_d = pc_q; kind_d = KIND_IDLE;
        sdone_d = 1'b0; mdone_d = 1'b0; mark = 1'b0; guard_clr = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= WK_HDR; pc_q <= '0; cnt_q <= '0; id_q <= '0; len_q <= '0;
      kind_q <= KIND_IDLE; hdr_q <= 1'b0; sdone_q <= 1'b0; mdone_q <= 1'b0;
    end else begin
      st_q <= st_d; pc_q <= pc_d; cnt_q <= cnt_d; id_q <= id_d; len_q <= len_d;
      kind_q <= kind_d; hdr_q <= hdr_d; sdone_q <= sdone_d; mdone_q <= mdone_d;
    end
  end

  assign pc_o       = pc_q;
  assign hdr_ok_o   = hdr_q;
  assign err_o      = (st_q == WK_HALT);
  assign sec_kind_o = kind_q;
  assign sec_id_o   = id_q;
  assign sec_len_o  = len_q;
  assign sec_done_o = sdone_q;
  assign mod_done_o = mdone_q;

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (err_o && $stable(pc_o))); // R2
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!sec_done_o && !mod_done_o)); // R2
  AST_CONT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WK_CONT) |-> (cnt_q != '0)); // R3
  AST_DONE_KIND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_done_o |-> (sec_kind_o == KIND_IDLE)); // R5
  AST_MOD_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    mod_done_o |-> (pc_o == '0 && !hdr_ok_o)); // R10
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((pc_o == $past(pc_o) + 1'b1) || pc_o == '0 || err_o)); // R12
  AST_PC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(pc_o)); // R12
endmodule

// File: tb/tb_bytecode_section_walker.sv
`timescale 1ns/1ps
module tb_bytecode_section_walker;
  localparam int PC_W = 32;
  localparam int LEN_W = 32;
  localparam int EV_SEC = 0, EV_MOD = 1, EV_ERR = 2;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [PC_W-1:0] total_len = '0;
  logic in_ready, hdr_ok_o, err_o, sec_done_o, mod_done_o;
  logic [PC_W-1:0] pc_o;
  logic [3:0] sec_kind_o;
  logic [7:0] sec_id_o;
  logic [LEN_W-1:0] sec_len_o;

  bytecode_section_walker #(.PC_W(PC_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .total_len(total_len), .pc_o(pc_o), .hdr_ok_o(hdr_ok_o),
    .err_o(err_o), .sec_kind_o(sec_kind_o), .sec_id_o(sec_id_o),
    .sec_len_o(sec_len_o), .sec_done_o(sec_done_o), .mod_done_o(mod_done_o));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] stim[$];
  int q_kind[$], q_id[$], q_len[$];
  string q_req[$];
  bit prev_err = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input int id, input int len, input string req);
    q_kind.push_back(kind); q_id.push_back(id); q_len.push_back(len); q_req.push_back(req);
  endtask

  task automatic add_hdr();
    stim.push_back(8'h00); stim.push_back(8'h61); stim.push_back(8'h73); stim.push_back(8'h6D);
    stim.push_back(8'h01); stim.push_back(8'h00); stim.push_back(8'h00); stim.push_back(8'h00);
  endtask

  task automatic add_sec(input int id, input int len);
    int v = len;
    stim.push_back(8'(id));
    do begin
      logic [7:0] b = 8'(v & 32'h7F);
      v = v >> 7;
      if (v != 0) b[7] = 1'b1;
      stim.push_back(b);
    end while (v != 0);
    for (int k = 0; k < len; k++) stim.push_back(8'(k * 3 + 1));
  endtask

  task automatic feed(input int n, input bit gap);
    int todo = (n < 0) ? stim.size() : n;
    for (int k = 0; k < todo; k++) begin
      @(negedge clk);
      if (!in_ready) begin
        in_valid = 1'b0;
        stim.delete();
        return;
      end
      in_valid = 1'b1;
      in_data = stim.pop_front();
      @(posedge clk);
      if (gap && (k % 3 == 1)) begin
        @(negedge clk); in_valid = 1'b0; @(posedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic settle(input string req);
    repeat (4) @(negedge clk);
    chk(q_kind.size() == 0, req, q_kind.size(), 0);
    q_kind.delete(); q_id.delete(); q_len.delete(); q_req.delete();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; stim.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Scoreboard monitor: pops expected events as strobes appear
  always @(negedge clk) begin
    if (!rst_n) prev_err = 1'b0;
    else begin
      if (sec_done_o) begin
        if (q_kind.size() == 0) chk(1'b0, "R3 unexpected section strobe", sec_id_o, -1);
        else begin
          chk(q_kind[0] == EV_SEC && q_id[0] == int'(sec_id_o) && q_len[0] == int'(sec_len_o),
              q_req[0], sec_id_o, q_id[0]);
          void'(q_kind.pop_front()); void'(q_id.pop_front());
          void'(q_len.pop_front()); void'(q_req.pop_front());
        end
      end
      if (mod_done_o) begin
        if (q_kind.size() == 0) chk(1'b0, "R10 unexpected module strobe", 1, 0);
        else begin
          chk(q_kind[0] == EV_MOD, q_req[0], EV_MOD, q_kind[0]);
          void'(q_kind.pop_front()); void'(q_id.pop_front());
          void'(q_len.pop_front()); void'(q_req.pop_front());
        end
      end
      if (err_o && !prev_err) begin
        if (q_kind.size() == 0) chk(1'b0, "R2 unexpected error", 1, 0);
        else begin
          chk(q_kind[0] == EV_ERR, q_req[0], EV_ERR, q_kind[0]);
          void'(q_kind.pop_front()); void'(q_id.pop_front());
          void'(q_len.pop_front()); void'(q_req.pop_front());
        end
      end
      prev_err = err_o;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R12 reset state
    chk(in_ready == 1'b1, "R12 ready after reset", in_ready, 1);
    chk(err_o == 1'b0 && hdr_ok_o == 1'b0, "R12 flags after reset", {err_o, hdr_ok_o}, 0);
    chk(pc_o == '0 && sec_kind_o == 4'hF, "R12 pc/kind after reset", sec_kind_o, 15);

    // Full module: sections 1, custom zero-length, 3 (two-byte length), 10
    add_hdr(); add_sec(1, 3); add_sec(0, 0); add_sec(3, 130); add_sec(10, 2);
    total_len = PC_W'(stim.size());
    expect_ev(EV_SEC, 1, 3, "R3 section 1");
    expect_ev(EV_SEC, 0, 0, "R4 zero-length custom");
    expect_ev(EV_SEC, 3, 130, "R3 multi-byte length");
    expect_ev(EV_SEC, 10, 2, "R6 skipped ids allowed");
    expect_ev(EV_MOD, 0, 0, "R10 module complete");
    feed(8, 1'b0);
    chk(hdr_ok_o == 1'b1, "R1 header accepted", hdr_ok_o, 1);
    chk(pc_o == 32'd8, "R12 pc counts header", pc_o, 8);
    feed(3, 1'b0);
    chk(sec_kind_o == 4'd1, "R5 kind during payload", sec_kind_o, 1);
    feed(-1, 1'b0);
    settle("R10 all events seen");
    chk(pc_o == '0 && hdr_ok_o == 1'b0, "R10 rearmed", pc_o, 0);
    chk(sec_kind_o == 4'hF, "R5 idle after module", sec_kind_o, 15);

    // Second module without reset, reusing ids, gaps in stream
    add_hdr(); add_sec(1, 1);
    stim.push_back(8'h00); stim.push_back(8'h80); stim.push_back(8'h00);
    add_sec(0, 2); add_sec(2, 1);
    total_len = PC_W'(stim.size());
    expect_ev(EV_SEC, 1, 1, "R10 id reuse after module");
    expect_ev(EV_SEC, 0, 0, "R4 non-minimal zero length");
    expect_ev(EV_SEC, 0, 2, "R7 custom repeated");
    expect_ev(EV_SEC, 2, 1, "R7 custom ignored by order");
    expect_ev(EV_MOD, 0, 0, "R12 gaps module complete");
    feed(-1, 1'b1);
    settle("R12 gapped events seen");

    // Bad header
    do_reset();
    add_hdr(); stim[2] = 8'h74;
    total_len = 32'd100;
    expect_ev(EV_ERR, 0, 0, "R2 header mismatch");
    feed(-1, 1'b0);
    settle("R2 events");
    chk(err_o == 1'b1 && in_ready == 1'b0, "R2 halted", in_ready, 0);
    chk(pc_o == 32'd2, "R2 pc frozen", pc_o, 2);

    // Duplicate id
    do_reset();
    add_hdr(); add_sec(2, 1); add_sec(2, 1);
    total_len = PC_W'(stim.size());
    expect_ev(EV_SEC, 2, 1, "R6 first section");
    expect_ev(EV_ERR, 0, 0, "R6 duplicate id");
    feed(-1, 1'b0);
    settle("R6 duplicate events");

    // Out of order
    do_reset();
    add_hdr(); add_sec(5, 1); add_sec(3, 1);
    total_len = PC_W'(stim.size());
    expect_ev(EV_SEC, 5, 1, "R6 first section");
    expect_ev(EV_ERR, 0, 0, "R6 lower id");
    feed(-1, 1'b0);
    settle("R6 order events");

    // Id too large
    do_reset();
    add_hdr(); add_sec(13, 1);
    total_len = PC_W'(stim.size());
    expect_ev(EV_ERR, 0, 0, "R8 id above range");
    feed(-1, 1'b0);
    settle("R8 events");

    // Length field too long
    do_reset();
    add_hdr(); stim.push_back(8'h01);
    for (int k = 0; k < 5; k++) stim.push_back(8'h80);
    stim.push_back(8'h00);
    total_len = 32'd100;
    expect_ev(EV_ERR, 0, 0, "R9 length overflow");
    feed(-1, 1'b0);
    settle("R9 events");

    // Truncated inside payload
    do_reset();
    add_hdr(); add_sec(1, 4);
    total_len = 32'd12;
    expect_ev(EV_ERR, 0, 0, "R11 ends in payload");
    feed(12, 1'b0);
    settle("R11 payload events");
    stim.delete();

    // Truncated inside header
    do_reset();
    add_hdr();
    total_len = 32'd5;
    expect_ev(EV_ERR, 0, 0, "R11 ends in header");
    feed(5, 1'b0);
    settle("R11 header events");
    chk(pc_o == 32'd4, "R11 pc at error", pc_o, 4);
    stim.delete();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule